// File: doc/BRIEF.md
# I2C Register Access Sequencer

This block carries out one complete single-byte register read or register write on a device behind an I2C bus. It does not drive the bus wires. Instead, it talks to a byte-level I2C master that takes command words. For each step, the sequencer issues a command word, plus an optional data byte, to that master. It then polls the master's status until the step has finished, and moves on to the next step.

The host side starts a transaction with a one-cycle read or write request. The request comes with a 7-bit device address, an 8-bit register address and, for writes, an 8-bit value. While the transaction runs, `busy` is high. At the end, exactly one of `done` or `error` pulses for one cycle. A read leaves the fetched byte on `rd_data`.

Polls are spaced by a programmable number of idle cycles. Each step has a bounded number of polls. If a step fails, whether by a missing acknowledge or by running out of polls, the sequencer sends a stop command and then reports the error.

Top module: `i2c_regseq`

## Requirements
- R1: The first byte of each addressed phase is `{dev_addr, dir}`, where dir is 0 for write and 1 for read. It is presented on `cmd_byte` with `cmd_byte_en` high. The register address and write value are also sent on `cmd_byte` with `cmd_byte_en` high. Stop-only and read commands carry no byte (`cmd_byte_en` low).
- R2: A register write issues exactly these commands, in this order, then pulses `done`:
  - 0x91 (address byte, dir 0)
  - 0x11 (register address)
  - 0x11 (write value)
  - 0x41 (stop)
- R3: A register read issues exactly these commands, in this order, then pulses `done`:
  - 0x91 (address byte, dir 0)
  - 0x11 (register address)
  - 0x91 (repeated start with address byte, dir 1)
  - 0x29 (read with NACK)
  - 0x41 (stop)

  `rd_data` takes the `bm_rdata` value that is sampled together with the status that ends the data phase.
- R4: Command word bits are: bit7 start, bit6 stop, bit5 read, bit4 write, bit3 send-NACK, bit0 interrupt-acknowledge. Every issued command word has bit0 set.
- R5: A phase is ready when status bit1 (transfer in progress) is clear. Every phase except the read's data phase and its final stop also requires status bit7 (NACK seen) to be clear. In those two phases, NACK is ignored.
- R6: A phase makes at most `MAX_POLLS` status polls. If none shows ready, the phase fails.
- R7: After each poll result, whether ready or not, at least `POLL_GAP` idle cycles pass before the next poll or command. Successive `poll_req` pulses are therefore at least `POLL_GAP`+2 cycles apart.
- R8: On a phase failure, the sequencer issues one command 0x41 (stop + acknowledge) with no byte. It then pulses `error` and issues nothing further.
- R9: `done` and `error` are one-cycle pulses, never high together, and exactly one of them ends each accepted transaction. `busy` is high from the cycle after acceptance until the end.
- R10: Requests arriving while busy are ignored. Address and data inputs are captured at acceptance, and later changes have no effect.
- R11: When `req_rd` and `req_wr` are high together in idle, a read is performed.
- R12: `rd_data` holds its value across writes and across reads that fail before the data phase completes. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_rd | input | 1 | Start a register read (one-cycle strobe) |
| req_wr | input | 1 | Start a register write (one-cycle strobe) |
| dev_addr | input | 7 | Target device address |
| reg_addr | input | 8 | Register address inside the device |
| wr_data | input | 8 | Value for a register write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse: transaction succeeded |
| error | output | 1 | One-cycle pulse: transaction aborted |
| rd_data | output | 8 | Last byte read |
| cmd_valid | output | 1 | Command write strobe to byte master |
| cmd_word | output | 8 | Command word |
| cmd_byte_en | output | 1 | Data byte accompanies the command |
| cmd_byte | output | 8 | Data byte for the byte master |
| poll_req | output | 1 | Status read request |
| bm_status | input | 8 | Master status, sampled one cycle after `poll_req` |
| bm_rdata | input | 8 | Master data register, sampled with `bm_status` |

## Verification
The bench plants a NACK on each phase in turn:
- On the write phases and the first three read phases, a NACK must abort the transaction. A design that ignored NACK there would report `done`.
- On the read's data and stop phases, a NACK must not abort. A design that checked it there would report `error` on a good read.

Timeouts are planted on the read's stop phase, which must still update `rd_data`, and on earlier phases, which must leave it alone. A timeout must cost exactly `MAX_POLLS` polls, so an off-by-one poll counter shows up as the wrong poll count before the stop.

Requests are injected mid-transaction, together with changed inputs. A design that restarted or re-sampled would emit extra commands or wrong bytes.

// File: rtl/i2c_regseq_pkg.sv
package i2c_regseq_pkg;

    // Command word bit encodings understood by the byte master
    localparam logic [7:0] CMD_START = 8'h80;
    localparam logic [7:0] CMD_STOP  = 8'h40;
    localparam logic [7:0] CMD_READ  = 8'h20;
    localparam logic [7:0] CMD_WRITE = 8'h10;
    localparam logic [7:0] CMD_NACK  = 8'h08;
    localparam logic [7:0] CMD_IACK  = 8'h01;

    // Status bit positions
    localparam int ST_NACK_BIT = 7;
    localparam int ST_TIP_BIT  = 1;

    localparam int STEP_W = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_POLL,
        S_SAMPLE,
        S_GAP,
        S_ABORT
    } seq_state_e;

    typedef struct packed {
        logic [7:0] word;     // command word to issue
        logic [7:0] data;     // byte written with the command
        logic       data_en;  // byte is meaningful
        logic       chk_ack;  // NACK status fails this phase
        logic       capture;  // latch master data when ready
        logic       last;     // final phase of the transaction
    } step_t;

endpackage

// File: rtl/i2c_regseq_steps.sv
module i2c_regseq_steps
    import i2c_regseq_pkg::*;
(
    input  logic              is_read,
    input  logic [STEP_W-1:0] step,
    input  logic [6:0]        dev,
    input  logic [7:0]        reg_a,
    input  logic [7:0]        wdata,
    output step_t             info
);

    always_comb begin
        info      = '0;
        info.word = CMD_IACK;
        case (step)
            3'd0: begin
                info.word    = CMD_START | CMD_WRITE | CMD_IACK;
                info.data    = {dev, 1'b0};
                info.data_en = 1'b1;
                info.chk_ack = 1'b1;
            end
            3'd1: begin
                info.word    = CMD_WRITE | CMD_IACK;
                info.data    = reg_a;
                info.data_en = 1'b1;
                info.chk_ack = 1'b1;
            end
            3'd2: begin
                if (is_read) begin
                    info.word = CMD_START | CMD_WRITE | CMD_IACK;
                    info.data = {dev, 1'b1};
                end else begin
                    info.word = CMD_WRITE | CMD_IACK;
                    info.data = wdata;
                end
                info.data_en = 1'b1;
                info.chk_ack = 1'b1;
            end
            3'd3: begin
                if (is_read) begin
                    info.word    = CMD_READ | CMD_NACK | CMD_IACK;
                    info.capture = 1'b1;
                end else begin
                    info.word    = CMD_STOP | CMD_IACK;
                    info.chk_ack = 1'b1;
                    info.last    = 1'b1;
                end
            end
            default: begin
                info.word = CMD_STOP | CMD_IACK;
                info.last = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/i2c_regseq_pacer.sv
module i2c_regseq_pacer #(
    parameter int POLL_GAP  = 10000,
    parameter int MAX_POLLS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sample,
    output logic gap_end,
    output logic exhausted
);

    localparam int GW = $clog2(POLL_GAP + 1);
    localparam int PW = $clog2(MAX_POLLS + 1);

    typedef struct packed {
        logic [GW-1:0] gap;
        logic [PW-1:0] polls;
    } pace_t;

    pace_t pace_d, pace_q;

    always_comb begin
        pace_d = pace_q;
        if (clr) begin
            pace_d.polls = '0;
        end
        if (sample) begin
            pace_d.gap   = GW'(POLL_GAP);
            pace_d.polls = pace_q.polls + 1'b1;
        end else if (pace_q.gap != '0) begin
            pace_d.gap = pace_q.gap - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pace_q <= '0;
        end else begin
            pace_q <= pace_d;
        end
    end

    assign gap_end   = (pace_q.gap == GW'(1));
    assign exhausted = (pace_q.polls >= PW'(MAX_POLLS));

endmodule

// File: rtl/i2c_regseq.sv
module i2c_regseq
    import i2c_regseq_pkg::*;
#(
    parameter int CLK_HZ    = 100_000_000,
    parameter int POLL_GAP  = CLK_HZ / 10_000,
    parameter int MAX_POLLS = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_rd,
    input  logic       req_wr,
    input  logic [6:0] dev_addr,
    input  logic [7:0] reg_addr,
    input  logic [7:0] wr_data,
    output logic       busy,
    output logic       done,
    output logic       error,
    output logic [7:0] rd_data,
    output logic       cmd_valid,
    output logic [7:0] cmd_word,
    output logic       cmd_byte_en,
    output logic [7:0] cmd_byte,
    output logic       poll_req,
    input  logic [7:0] bm_status,
    input  logic [7:0] bm_rdata
);

    typedef struct packed {
        seq_state_e        state;
        logic [STEP_W-1:0] step;
        logic              is_read;
        logic [6:0]        dev;
        logic [7:0]        reg_a;
        logic [7:0]        wdata;
        logic [7:0]        rdata;
        logic              ready;
        logic              done;
        logic              error;
    } seq_t;

    seq_t  seq_d, seq_q;
    step_t cur;
    logic  pace_clr, pace_sample, gap_end, exhausted;
    logic  phase_ready;

    i2c_regseq_steps u_steps (
        .is_read (seq_q.is_read),
        .step    (seq_q.step),
        .dev     (seq_q.dev),
        .reg_a   (seq_q.reg_a),
        .wdata   (seq_q.wdata),
        .info    (cur)
    );

    i2c_regseq_pacer #(
        .POLL_GAP  (POLL_GAP),
        .MAX_POLLS (MAX_POLLS)
    ) u_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pace_clr),
        .sample    (pace_sample),
        .gap_end   (gap_end),
        .exhausted (exhausted)
    );

    assign phase_ready = !bm_status[ST_TIP_BIT]
                       && !(cur.chk_ack && bm_status[ST_NACK_BIT]);

    always_comb begin
        seq_d       = seq_q;
        seq_d.done  = 1'b0;
        seq_d.error = 1'b0;
        cmd_valid   = 1'b0;
        cmd_word    = '0;
        cmd_byte_en = 1'b0;
        cmd_byte    = '0;
        poll_req    = 1'b0;
        pace_clr    = 1'b0;
        pace_sample = 1'b0;

        case (seq_q.state)
            S_IDLE: begin
                if (req_rd || req_wr) begin
                    seq_d.is_read = req_rd;
                    seq_d.dev     = dev_addr;
                    seq_d.reg_a   = reg_addr;
                    seq_d.wdata   = wr_data;
                    seq_d.step    = '0;
                    seq_d.state   = S_ISSUE;
                end
            end
            S_ISSUE: begin
                cmd_valid   = 1'b1;
                cmd_word    = cur.word;
                cmd_byte_en = cur.data_en;
                cmd_byte    = cur.data_en ? cur.data : 8'h00;
                pace_clr    = 1'b1;
                seq_d.state = S_POLL;
            end
            S_POLL: begin
                poll_req    = 1'b1;
                seq_d.state = S_SAMPLE;
            end
            S_SAMPLE: begin
                pace_sample = 1'b1;
                seq_d.ready = phase_ready;
                if (phase_ready && cur.capture) begin
                    seq_d.rdata = bm_rdata;
                end
                seq_d.state = S_GAP;
            end
            S_GAP: begin
                if (gap_end) begin
                    if (seq_q.ready) begin
                        if (cur.last) begin
                            seq_d.done  = 1'b1;
                            seq_d.state = S_IDLE;
                        end else begin
                            seq_d.step  = seq_q.step + 1'b1;
                            seq_d.state = S_ISSUE;
                        end
                    end else if (exhausted) begin
                        seq_d.state = S_ABORT;
                    end else begin
                        seq_d.state = S_POLL;
                    end
                end
            end
            S_ABORT: begin
                cmd_valid   = 1'b1;
                cmd_word    = CMD_STOP | CMD_IACK;
                seq_d.error = 1'b1;
                seq_d.state = S_IDLE;
            end
            default: begin
                seq_d.state = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= S_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy    = (seq_q.state != S_IDLE);
    assign done    = seq_q.done;
    assign error   = seq_q.error;
    assign rd_data = seq_q.rdata;

endmodule

// File: rtl/i2c_regseq_chk.sv
module i2c_regseq_chk #(
    parameter int POLL_GAP  = 10000,
    parameter int MAX_POLLS = 50
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       error,
    input logic       cmd_valid,
    input logic [7:0] cmd_word,
    input logic       cmd_byte_en,
    input logic       poll_req
);

    localparam int GW = $clog2(POLL_GAP + 2) + 1;
    localparam int PW = $clog2(MAX_POLLS + 1) + 1;
    localparam logic [GW-1:0] GAP_MIN = GW'(POLL_GAP + 1);

    logic [GW-1:0] since_q;
    logic          seen_q;
    logic [PW-1:0] polls_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
            seen_q  <= 1'b0;
            polls_q <= '0;
        end else begin
            if (poll_req) begin
                since_q <= '0;
                seen_q  <= 1'b1;
            end else if (since_q < GAP_MIN) begin
                since_q <= since_q + 1'b1;
            end
            if (cmd_valid) begin
                polls_q <= '0;
            end else if (poll_req) begin
                polls_q <= polls_q + 1'b1;
            end
        end
    end

    a_r4_iack_set: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_word[0]);

    a_r1_start_has_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[7]) |-> cmd_byte_en);

    a_r7_poll_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_req && seen_q) |-> (since_q >= GAP_MIN));

    a_r6_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |-> (polls_q < PW'(MAX_POLLS)));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_error_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error);

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cmd_valid && !poll_req));

    a_r8_abort_stop: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> ($past(cmd_valid) && $past(cmd_word) == 8'h41));

endmodule

bind i2c_regseq i2c_regseq_chk #(
    .POLL_GAP  (POLL_GAP),
    .MAX_POLLS (MAX_POLLS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .error       (error),
    .cmd_valid   (cmd_valid),
    .cmd_word    (cmd_word),
    .cmd_byte_en (cmd_byte_en),
    .poll_req    (poll_req)
);

// File: tb/sim_i2c_regseq.sv
module sim_i2c_regseq;

    localparam int GAP  = 4;
    localparam int MAXP = 50;
    localparam int FM_NONE = 0, FM_NACK = 1, FM_TO = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic       req_rd = 1'b0, req_wr = 1'b0;
    logic [6:0] dev_addr = '0;
    logic [7:0] reg_addr = '0, wr_data = '0, bm_rdata = '0, bm_status = '0;
    logic       busy, done, error, cmd_valid, cmd_byte_en, poll_req;
    logic [7:0] rd_data, cmd_word, cmd_byte;

    i2c_regseq #(.POLL_GAP(GAP), .MAX_POLLS(MAXP)) u0 (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
        .dev_addr(dev_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .error(error), .rd_data(rd_data),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_byte_en(cmd_byte_en),
        .cmd_byte(cmd_byte), .poll_req(poll_req), .bm_status(bm_status),
        .bm_rdata(bm_rdata)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    // byte-master model
    int busy_n = 0, fmode = 0, fidx = 0;
    int base_cmd = 0, cmd_cnt = 0, cur_rel = 0, polls_since = 0;

    function automatic logic [7:0] model_status(int rel, int np);
        if (fmode == FM_TO && rel == fidx) return 8'h02;
        if (np < busy_n) return 8'h02;
        if (fmode == FM_NACK && rel == fidx) return 8'h80;
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (cmd_valid) begin
            cur_rel     <= cmd_cnt - base_cmd;
            cmd_cnt     <= cmd_cnt + 1;
            polls_since <= 0;
        end else if (poll_req) begin
            bm_status   <= model_status(cur_rel, polls_since);
            polls_since <= polls_since + 1;
        end
    end

    // monitor
    logic [16:0] log_q [0:4095];
    int run_q [0:4095];
    int log_n = 0, poll_run = 0, cyc = 0, last_poll = -1000, min_space = 100000;
    int done_n = 0, err_n = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (cmd_valid) begin
                log_q[log_n] = {cmd_byte_en, cmd_word, cmd_byte};
                run_q[log_n] = poll_run;
                log_n = log_n + 1;
                poll_run = 0;
            end
            if (poll_req) begin
                if (cyc - last_poll < min_space) min_space = cyc - last_poll;
                last_poll = cyc;
                poll_run = poll_run + 1;
            end
            if (done) done_n = done_n + 1;
            if (error) err_n = err_n + 1;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit ack_checked(bit rd, int i);
        return !rd || i < 3;
    endfunction

    function automatic logic [16:0] exp_cmd(bit rd, int i, logic [6:0] d,
                                            logic [7:0] r, logic [7:0] w);
        case (i)
            0: return {1'b1, 8'h91, d, 1'b0};
            1: return {1'b1, 8'h11, r};
            2: return rd ? {1'b1, 8'h91, d, 1'b1} : {1'b1, 8'h11, w};
            3: return rd ? {1'b0, 8'h29, 8'h00} : {1'b0, 8'h41, 8'h00};
            default: return {1'b0, 8'h41, 8'h00};
        endcase
    endfunction

    logic [7:0] exp_rd = 8'h00;

    task automatic run_txn(bit both, bit rd, logic [6:0] d, logic [7:0] r,
                           logic [7:0] w, logic [7:0] mrd, int bn, int fm,
                           int fi, bit poke);
        int lb, d0, e0, nsteps, nexp, wcnt;
        bit fail;
        string tag;
        @(negedge clk);
        busy_n = bn; fmode = fm; fidx = fi; base_cmd = cmd_cnt;
        lb = log_n; d0 = done_n; e0 = err_n;
        bm_rdata = mrd; dev_addr = d; reg_addr = r; wr_data = w;
        req_rd = rd | both; req_wr = !rd | both;
        @(negedge clk);
        req_rd = 0; req_wr = 0;
        chk(busy == 1'b1, "R9", "busy after accept", busy, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            dev_addr = ~d; reg_addr = ~r; wr_data = ~w; req_rd = 1; req_wr = 1;
            @(negedge clk);
            req_rd = 0; req_wr = 0;
        end
        wcnt = 0;
        while (done_n == d0 && err_n == e0 && wcnt < 8000) begin
            @(negedge clk);
            wcnt++;
        end
        repeat (GAP + 12) @(negedge clk);
        if (both) rd = 1;
        nsteps = rd ? 5 : 4;
        fail = (fm == FM_TO && fi < nsteps) ||
               (fm == FM_NACK && fi < nsteps && ack_checked(rd, fi));
        nexp = fail ? fi + 2 : nsteps;
        tag = fail ? "R8" : (rd ? "R3" : "R2");
        if (both) tag = "R11";
        if (poke) tag = "R10";
        chk(log_n - lb == nexp, tag, "command count", log_n - lb, nexp);
        for (int i = 0; i < nexp && i < log_n - lb; i++) begin
            logic [16:0] e, a;
            e = (fail && i == nexp - 1) ? {1'b0, 8'h41, 8'h00} : exp_cmd(rd, i, d, r, w);
            a = log_q[lb + i];
            if (!e[16]) begin e[7:0] = 8'h00; a[7:0] = 8'h00; end
            chk(a == e, (i == 0 || i == 2) ? "R1" : tag, "command", a, e);
            chk(log_q[lb + i][8], "R4", "iack bit", log_q[lb + i][15:8], 1);
        end
        if (fail && fm == FM_TO && log_n - lb == nexp)
            chk(run_q[lb + nexp - 1] == MAXP, "R6", "polls before abort",
                run_q[lb + nexp - 1], MAXP);
        if (fm == FM_NACK && rd && fi >= 3)
            chk(done_n - d0 == 1, "R5", "nack ignored in read tail", done_n - d0, 1);
        chk(done_n - d0 == int'(!fail), "R9", "done pulses", done_n - d0, int'(!fail));
        chk(err_n - e0 == int'(fail), "R9", "error pulses", err_n - e0, int'(fail));
        chk(busy == 1'b0, "R9", "busy at end", busy, 0);
        if (rd && (!fail || (fm == FM_TO && fi == 4))) exp_rd = mrd;
        chk(rd_data == exp_rd, rd ? "R3" : "R12", "rd_data", rd_data, exp_rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1c2b));
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && error == 0, "R9", "reset outputs",
            {busy, done, error}, 0);
        chk(cmd_valid == 0 && poll_req == 0, "R9", "reset strobes",
            {cmd_valid, poll_req}, 0);
        chk(rd_data == 8'h00, "R12", "reset rd_data", rd_data, 0);
        rst_n = 1'b1;
        // directed corners
        run_txn(0, 0, 7'h50, 8'h12, 8'hA5, 8'h00, 0, FM_NONE, 0, 0);
        run_txn(0, 1, 7'h2C, 8'h34, 8'h00, 8'h5A, 1, FM_NONE, 0, 0);
        for (int i = 0; i < 4; i++)
            run_txn(0, 0, 7'h11, 8'h40, 8'h0F, 8'h00, 0, FM_NACK, i, 0);
        for (int i = 0; i < 5; i++)
            run_txn(0, 1, 7'h7F, 8'hFE, 8'h00, 8'h30 + 8'(i), 2, FM_NACK, i, 0);
        run_txn(0, 1, 7'h01, 8'h02, 8'h00, 8'hC3, 0, FM_TO, 4, 0);
        run_txn(0, 1, 7'h01, 8'h02, 8'h00, 8'h99, 0, FM_TO, 3, 0);
        run_txn(0, 0, 7'h22, 8'h33, 8'h44, 8'h00, 0, FM_TO, 1, 0);
        run_txn(1, 0, 7'h3A, 8'h77, 8'h88, 8'h6E, 1, FM_NONE, 0, 0);
        run_txn(0, 0, 7'h45, 8'h56, 8'h67, 8'h00, 3, FM_NONE, 0, 1);
        // constrained random
        for (int k = 0; k < 80; k++) begin
            int fm, r;
            r = $urandom_range(0, 9);
            fm = (r < 6) ? FM_NONE : (r < 9) ? FM_NACK : FM_TO;
            run_txn(0, 1'($urandom_range(0, 1)), 7'($urandom), 8'($urandom),
                    8'($urandom), 8'($urandom), $urandom_range(0, 3), fm,
                    $urandom_range(0, 4), $urandom_range(0, 7) == 0);
        end
        chk(min_space >= GAP + 2, "R7", "poll spacing", min_space, GAP + 2);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule